// File: doc/BRIEF.md
# Staggered Per-Bank Refresh Scheduler

This block decides when each bank of a multi-bank DRAM gets refreshed. Refreshes go to one bank at a time, and neighbouring banks are one clock apart. Every bank moves through two steps in each refresh interval. First a precharge trigger closes the bank's open row, if there is one. A fixed gap later, a refresh trigger sends a per-bank refresh command. All trigger times are absolute values on a free-running cycle-time input. The refresh interval, the precharge time and the bank count are elaboration parameters, all given in clock cycles.

The scheduler offers commands on a valid/ready output. A command stays on the outputs, unchanged, until the controller accepts it with `cmd_ready`. While a command waits, no further trigger is serviced. Triggers that come due in that time stay pending and are serviced later, earliest first. When `cmd_valid` is low the command code reads NOP. The `wait_cycles` output gives the number of cycles until the earliest pending trigger, so the controller can plan other traffic around it.

Top module: `refresh_stagger_sched`

## Requirements
- R1: After reset, `cmd_valid` is 0, `cmd_op` is NOP (code 0) and every bank is idle. With cycle time 0, `wait_cycles` equals bank 0's first precharge trigger time.
- R2: Bank i first gets its refresh trigger at cycle T_REFI-(NUM_BANKS-1)+i. Its precharge trigger comes max(NUM_BANKS, T_RP) cycles before that.
- R3: A trigger that has been serviced is moved to exactly T_REFI cycles after its previous due time.
- R4: A trigger for an idle bank moves that bank into its refreshing state. If `bank_open` is 1 for the bank, the trigger offers PRE (code 1). If not, no command is offered.
- R5: A trigger for a bank in the refreshing state returns the bank to idle and offers a per-bank refresh (code 2) for that bank.
- R6: At most one trigger is serviced per cycle, and it is the one with the earliest due time. When due times are equal, the lower bank index goes first. Triggers not serviced stay pending.
- R7: While `cmd_valid` is 1 and `cmd_ready` is 0, the command code and the bank stay unchanged and no trigger is serviced.
- R8: When a trigger is serviced in the cycle where the cycle time equals its due time, its command appears on the outputs in the next cycle. When no command is offered, `cmd_valid` is 0 and `cmd_op` is NOP.
- R9: `wait_cycles` is the earliest pending due time minus the current cycle time. It is 0 when that trigger is due or overdue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_time | input | TIME_W | Free-running cycle count, advancing by one per clock |
| bank_open | input | NUM_BANKS | One bit per bank: the bank has an open row |
| cmd_ready | input | 1 | Controller accepts the offered command |
| cmd_valid | output | 1 | A command is offered |
| cmd_op | output | 2 | 0 NOP, 1 PRE, 2 per-bank refresh |
| cmd_bank | output | BANK_W | Target bank of the offered command |
| wait_cycles | output | TIME_W | Cycles until the earliest pending trigger |

## Verification
A trigger that is serviced in the cycle whose cycle time is T puts its command on the outputs at cycle T+1. `wait_cycles` is combinational, so it follows the cycle time within the same cycle. The bench drives inputs on the falling edge and samples one step later. It predicts each command together with the cycle in which that command must first appear, and it compares `cmd_valid` and `wait_cycles` against its own model on every cycle. Stretches of back-pressure pile up overdue triggers, which tests that they are served in the right order.

// File: rtl/refsch_pkg.sv
package refsch_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_PRE  = 2'd1,
    OP_REFB = 2'd2
  } op_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/refsch_bank.sv
module refsch_bank #(
  parameter int TIME_W   = 16,
  parameter int T_REFI   = 3900,
  parameter int PRE_INIT = 100,
  parameter int REF_INIT = 111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  output logic [TIME_W-1:0] next_due,
  output logic              busy
);
  localparam logic [TIME_W-1:0] STEP = TIME_W'(T_REFI);

  logic [TIME_W-1:0] pre_due;
  logic [TIME_W-1:0] ref_due;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_due <= TIME_W'(PRE_INIT);
      ref_due <= TIME_W'(REF_INIT);
      busy    <= 1'b0;
    end else if (fire) begin
      if (busy) begin
        ref_due <= ref_due + STEP;
        busy    <= 1'b0;
      end else begin
        pre_due <= pre_due + STEP;
        busy    <= 1'b1;
      end
    end
  end

  assign next_due = busy ? ref_due : pre_due;
endmodule

// File: rtl/refsch_pick.sv
module refsch_pick #(
  parameter int NUM_BANKS = 8,
  parameter int TIME_W    = 16,
  parameter int BANK_W    = 3
) (
  input  logic [NUM_BANKS-1:0][TIME_W-1:0] due,
  input  logic [TIME_W-1:0]                now,
  output logic                             any_due,
  output logic [BANK_W-1:0]                sel,
  output logic [TIME_W-1:0]                wait_out
);
  logic signed [TIME_W-1:0] best;
  logic signed [TIME_W-1:0] diff;

  always_comb begin
    best = $signed(due[0] - now);
    sel  = '0;
    diff = '0;
    for (int i = 1; i < NUM_BANKS; i++) begin
      diff = $signed(due[i] - now);
      if (diff < best) begin
        best = diff;
        sel  = BANK_W'(i);
      end
    end
    any_due  = (best <= 0);
    wait_out = any_due ? '0 : $unsigned(best);
  end
endmodule

// File: rtl/refresh_stagger_sched.sv
module refresh_stagger_sched #(
  parameter int NUM_BANKS = 8,
  parameter int T_REFI    = 3900,
  parameter int T_RP      = 11,
  parameter int TIME_W    = 16,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TIME_W-1:0]    cycle_time,
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic                 cmd_ready,
  output logic                 cmd_valid,
  output logic [1:0]           cmd_op,
  output logic [BANK_W-1:0]    cmd_bank,
  output logic [TIME_W-1:0]    wait_cycles
);
  import refsch_pkg::*;

  localparam int PRE_GAP = max_int(NUM_BANKS, T_RP);
  localparam int REF0    = T_REFI - (NUM_BANKS - 1);

  logic [NUM_BANKS-1:0][TIME_W-1:0] due;
  logic [NUM_BANKS-1:0]             bank_busy;
  logic [NUM_BANKS-1:0]             fire_vec;
  logic                             any_due;
  logic [BANK_W-1:0]                sel;
  logic                             fire;
  logic                             sel_busy;
  logic                             sel_open;

  assign fire     = any_due && (!cmd_valid || cmd_ready);
  assign sel_busy = bank_busy[sel];
  assign sel_open = bank_open[sel];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign fire_vec[g] = fire && (sel == BANK_W'(g));
    refsch_bank #(
      .TIME_W  (TIME_W),
      .T_REFI  (T_REFI),
      .PRE_INIT(REF0 + g - PRE_GAP),
      .REF_INIT(REF0 + g)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (fire_vec[g]),
      .next_due(due[g]),
      .busy    (bank_busy[g])
    );
  end

  refsch_pick #(
    .NUM_BANKS(NUM_BANKS),
    .TIME_W   (TIME_W),
    .BANK_W   (BANK_W)
  ) u_pick (
    .due     (due),
    .now     (cycle_time),
    .any_due (any_due),
    .sel     (sel),
    .wait_out(wait_cycles)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_op    <= OP_NOP;
      cmd_bank  <= '0;
    end else if (fire) begin
      cmd_bank <= sel;
      if (sel_busy) begin
        cmd_valid <= 1'b1;
        cmd_op    <= OP_REFB;
      end else if (sel_open) begin
        cmd_valid <= 1'b1;
        cmd_op    <= OP_PRE;
      end else begin
        cmd_valid <= 1'b0;
        cmd_op    <= OP_NOP;
      end
    end else if (cmd_valid && cmd_ready) begin
      cmd_valid <= 1'b0;
      cmd_op    <= OP_NOP;
    end
  end
endmodule

// File: rtl/refsch_chk.sv
module refsch_chk #(
  parameter int NUM_BANKS = 8,
  parameter int TIME_W    = 16,
  parameter int BANK_W    = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [TIME_W-1:0]    cycle_time,
  input logic                 cmd_ready,
  input logic                 cmd_valid,
  input logic [1:0]           cmd_op,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic [TIME_W-1:0]    wait_cycles,
  input logic [NUM_BANKS-1:0] bank_busy
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_bank))); // R7

  AST_HOLD_NO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> $stable(bank_busy)); // R7

  AST_IDLE_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (cmd_op == 2'd0)); // R8

  AST_VALID_HAS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_op == 2'd1 || cmd_op == 2'd2)); // R4

  AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (int'(cmd_bank) < NUM_BANKS)); // R6

  AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ($countones(bank_busy ^ $past(bank_busy)) <= 1)); // R6

  AST_REFB_LEAVES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_valid) && cmd_op == 2'd2) |-> !bank_busy[cmd_bank]); // R5

  AST_WAIT_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_cycles > 1) |=> ((cycle_time != $past(cycle_time) + 1'b1) ||
                           (wait_cycles == $past(wait_cycles) - 1'b1))); // R9
endmodule

bind refresh_stagger_sched refsch_chk #(
  .NUM_BANKS(NUM_BANKS),
  .TIME_W   (TIME_W),
  .BANK_W   (BANK_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cycle_time (cycle_time),
  .cmd_ready  (cmd_ready),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_bank   (cmd_bank),
  .wait_cycles(wait_cycles),
  .bank_busy  (bank_busy)
);

// File: tb/sim_refresh_stagger_sched.sv
`timescale 1ns/1ps
module sim_refresh_stagger_sched;
  localparam int NB    = 4;
  localparam int REFI  = 64;
  localparam int TRP   = 3;
  localparam int TW    = 12;
  localparam int BW    = 2;
  localparam int GAP   = (NB > TRP) ? NB : TRP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] cycle_time = '0;
  logic [NB-1:0] bank_open = '0;
  logic          cmd_ready = 1'b0;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [BW-1:0] cmd_bank;
  logic [TW-1:0] wait_cycles;

  always #4 clk = ~clk;

  refresh_stagger_sched #(.NUM_BANKS(NB), .T_REFI(REFI), .T_RP(TRP), .TIME_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .cycle_time(cycle_time), .bank_open(bank_open),
    .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .wait_cycles(wait_cycles)
  );

  typedef struct { int t; int op; int bank; } item_t;
  item_t q[$];

  int total = 0;
  int fails = 0;
  int m_pre[NB];
  int m_ref[NB];
  bit m_busy[NB];
  bit m_valid = 0;
  bit started = 0;
  bit seen = 0;
  int start_t = 0;
  int t = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, t);
    end
  endtask

  task automatic step(input bit r, input logic [NB-1:0] o);
    int best, bsel, d, w;
    bit fire;
    @(negedge clk);
    cycle_time = TW'(t);
    cmd_ready  = r;
    bank_open  = o;
    #1;
    best = 1 << 20; bsel = 0;
    for (int i = 0; i < NB; i++) begin
      d = (m_busy[i] ? m_ref[i] : m_pre[i]) - t;
      if (d < best) begin best = d; bsel = i; end
    end
    w = (best <= 0) ? 0 : best;
    check(int'(wait_cycles) == w, (t == 0) ? "R1 wait" : "R9 wait", int'(wait_cycles), w);
    check(cmd_valid == m_valid, "R7 valid", int'(cmd_valid), int'(m_valid));
    if (!cmd_valid) check(cmd_op == 2'd0, "R8 nop", int'(cmd_op), 0);
    fire = (best <= 0) && (!m_valid || r);
    if (fire) begin
      if (m_busy[bsel]) begin
        m_busy[bsel] = 0; m_ref[bsel] += REFI; m_valid = 1;
        q.push_back('{t: t + 1, op: 2, bank: bsel});
      end else begin
        m_busy[bsel] = 1; m_pre[bsel] += REFI;
        m_valid = o[bsel];
        if (o[bsel]) q.push_back('{t: t + 1, op: 1, bank: bsel});
      end
    end else if (m_valid && r) begin
      m_valid = 0;
    end
    t++;
  endtask

  // monitor: pops expected items on each accepted command
  always @(negedge clk) begin
    item_t it;
    #2;
    if (started) begin
      if (cmd_valid && !seen) begin seen = 1; start_t = t - 1; end
      if (cmd_valid && cmd_ready) begin
        seen = 0;
        if (q.size() == 0) begin
          check(0, "R6 unexpected command", int'(cmd_bank), -1);
        end else begin
          it = q.pop_front();
          check(int'(cmd_op) == it.op, (it.op == 1) ? "R4 op" : "R5 op", int'(cmd_op), it.op);
          check(int'(cmd_bank) == it.bank, "R6 bank order", int'(cmd_bank), it.bank);
          check(start_t == it.t, (it.t <= REFI + NB) ? "R2 timing" : "R3 timing", start_t, it.t);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    bit r;
    logic [NB-1:0] o;
    for (int i = 0; i < NB; i++) begin
      m_ref[i]  = REFI - (NB - 1) + i;
      m_pre[i]  = m_ref[i] - GAP;
      m_busy[i] = 0;
    end
    repeat (3) @(negedge clk);
    check(cmd_valid == 1'b0, "R1 reset valid", int'(cmd_valid), 0);
    check(cmd_op == 2'd0, "R1 reset op", int'(cmd_op), 0);
    @(negedge clk);
    rst_n = 1'b1;
    started = 1;
    lfsr = 16'hACE1;
    for (int c = 0; c < 1000; c++) begin
      // bank-open pattern changes per interval
      case ((c / REFI) % 4)
        0: o = 4'b0101;
        1: o = 4'b1111;
        2: o = 4'b0000;
        default: o = 4'b1010;
      endcase
      if (c < 192) r = 1;
      else if (c < 384) r = !((c % REFI) >= 52 && (c % REFI) < 62);
      else if (c < 900) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        r = (lfsr[1:0] != 2'b00) || !lfsr[2];
      end else r = 1;
      step(r, o);
    end
    step(1, '0);
    step(1, '0);
    check(q.size() == 0, "R8 all commands delivered", q.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule